// File: doc/BRIEF.md
# Bus fault status capture unit

This block keeps a sticky record of why bus faults happened in a small processor core. The core sends it single-cycle event strobes: a fetch error reported against a prefetch slot, the issue of an instruction from a slot, precise and imprecise data errors, and errors seen while pushing or popping an exception frame. Each cause sets its own flag in a status register. Software reads the flags and clears them by writing ones. A precise data error also records the faulting data address in an address register that has its own valid flag.

An error reported at prefetch is not a fault in itself. It is held as a tag on the fetch slot and becomes a fault only if the core issues that instruction. A flush discards every tag. An imprecise data error is held as pending until the current execution priority is numerically greater than the bus fault priority (a larger number means a lower priority). Only then is its flag set. Two outputs show what the stack logic may do: the stack pointer adjustment on exception entry is granted even when stacking failed, and the stack pointer restore on return is withheld when unstacking failed.

Top module: `bus_fault_capture`

## Requirements
- R1: After reset the flags, the address valid flag and the imprecise pending output are all 0, and the status register reads 0.
- R2: Flag positions are: bit 0 instruction fetch error, bit 1 precise data error, bit 2 imprecise data error, bit 3 unstacking error, bit 4 stacking error. A write to register select 0 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. A flag that is set and cleared in the same cycle ends up set.
- R3: A precise error sets bit 1. If the address valid flag is 0, the error also loads its address into the fault address register and sets the valid flag, visible on the cycle after the strobe.
- R4: While the valid flag is 1, a later precise error leaves the address unchanged. Clearing bit 1 clears the valid flag. A precise error in the same cycle as a clear of bit 1 loads its address and leaves the valid flag set.
- R5: Fetch, imprecise, stacking and unstacking errors never change the fault address or the valid flag.
- R6: A fetch error tags its slot. Bit 0 is set only when the core issues from a tagged slot. Issuing from an untagged slot sets nothing, and a flush clears all tags so that a later issue sets nothing.
- R7: An imprecise error sets bit 2 on the next cycle if exec_prio > fault_prio. Otherwise it is held in imp_pending, and bit 2 is set on the cycle after the priorities first satisfy exec_prio > fault_prio. imp_pending then returns to 0.
- R8: A precise error that arrives while an imprecise error is pending sets bit 1 at once, leaves the fault pending, and after delivery bits 1 and 2 are both set.
- R9: Any number of stacking errors set bit 4. sp_adjust follows stk_done whether or not stacking failed.
- R10: An unstacking error sets bit 3. sp_restore is 0 for the unstk_done of a return during which an unstacking error was seen, including in the same cycle, and is 1 for a clean return.
- R11: reg_rdata at select 0 gives the flags in bits 4:0 and the address valid flag in bit 7, with all other bits 0. At select 1 it gives the fault address. A write to select 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_err | input | 1 | Bus error on a prefetch |
| fetch_slot | input | TW | Slot of the erroring prefetch |
| issue | input | 1 | Instruction issued |
| issue_slot | input | TW | Slot the instruction is issued from |
| flush | input | 1 | Discard all prefetch tags |
| prec_err | input | 1 | Precise data bus error |
| prec_addr | input | AW | Address of the precise error |
| imp_err | input | 1 | Imprecise data bus error |
| exec_prio | input | PW | Current execution priority (larger = lower) |
| fault_prio | input | PW | Bus fault priority |
| stk_err | input | 1 | Error while stacking on entry |
| stk_done | input | 1 | Entry stacking finished |
| unstk_err | input | 1 | Error while unstacking on return |
| unstk_done | input | 1 | Return unstacking finished |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 status, 1 fault address |
| reg_wdata | input | AW | Write data |
| reg_rdata | output | AW | Read data for reg_sel |
| flags | output | 5 | Sticky fault flags |
| fault_addr | output | AW | Captured precise fault address |
| addr_valid | output | 1 | fault_addr holds a captured address |
| imp_pending | output | 1 | Imprecise fault waiting on priority |
| sp_adjust | output | 1 | Stack pointer adjustment granted |
| sp_restore | output | 1 | Stack pointer restore granted |

## Verification
The bench builds the block with AW=8, NTAG=4 and PW=2. With these values it can try all 32 clear masks over a fully set status field, all 16 pairs of execution and fault priority for an imprecise error, and every fetch slot against a matching issue, a mismatched issue and a flush. The narrow address makes capture, hold and recapture easy to tell apart by their values.

// File: rtl/bus_fault_capture.sv
module bus_fault_capture #(
  parameter int AW   = 32,
  parameter int NTAG = 4,
  parameter int PW   = 3,
  localparam int TW  = (NTAG > 1) ? $clog2(NTAG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_err,
  input  logic [TW-1:0] fetch_slot,
  input  logic          issue,
  input  logic [TW-1:0] issue_slot,
  input  logic          flush,
  input  logic          prec_err,
  input  logic [AW-1:0] prec_addr,
  input  logic          imp_err,
  input  logic [PW-1:0] exec_prio,
  input  logic [PW-1:0] fault_prio,
  input  logic          stk_err,
  input  logic          stk_done,
  input  logic          unstk_err,
  input  logic          unstk_done,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic [4:0]    flags,
  output logic [AW-1:0] fault_addr,
  output logic          addr_valid,
  output logic          imp_pending,
  output logic          sp_adjust,
  output logic          sp_restore
);

  logic [NTAG-1:0] tag;
  logic            unstk_seen;

  wire       clr_wr   = reg_wr && !reg_sel;
  wire [4:0] clr      = clr_wr ? reg_wdata[4:0] : 5'd0;
  wire       imp_live = imp_pending || imp_err;
  wire       imp_go   = imp_live && (exec_prio > fault_prio);
  wire       ibus_hit = issue && tag[issue_slot];
  wire [4:0] set      = {stk_err, unstk_err, imp_go, prec_err, ibus_hit};
  wire       capture  = prec_err && (!addr_valid || clr[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags       <= '0;
      fault_addr  <= '0;
      addr_valid  <= 1'b0;
      imp_pending <= 1'b0;
      unstk_seen  <= 1'b0;
    end else begin
      flags       <= (flags & ~clr) | set;
      imp_pending <= imp_live && !imp_go;
      unstk_seen  <= unstk_done ? 1'b0 : (unstk_seen || unstk_err);
      if (capture) fault_addr <= prec_addr;
      if (capture) addr_valid <= 1'b1;
      else if (clr[1]) addr_valid <= 1'b0;
    end
  end

  for (genvar i = 0; i < NTAG; i++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag[i] <= 1'b0;
      else if (fetch_err && fetch_slot == TW'(i)) tag[i] <= 1'b1;
      else if (flush || (issue && issue_slot == TW'(i))) tag[i] <= 1'b0;
    end
  end

  assign sp_adjust  = stk_done;
  assign sp_restore = unstk_done && !unstk_seen && !unstk_err;

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) reg_rdata = fault_addr;
    else begin
      reg_rdata[4:0] = flags;
      reg_rdata[7]   = addr_valid;
    end
  end

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((flags & $past(flags)) == $past(flags)));
  assert_prec_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prec_err |=> flags[1]);
  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prec_err && !addr_valid) |=> (addr_valid && fault_addr == $past(prec_addr)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !(clr_wr && reg_wdata[1])) |=> (addr_valid && $stable(fault_addr)));
  assert_no_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!prec_err && !clr_wr) |=> ($stable(fault_addr) && $stable(addr_valid)));
  assert_imp_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (imp_pending && exec_prio <= fault_prio) |=> imp_pending);
  assert_stk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> flags[4]);
  assert_adjust_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_done |-> sp_adjust);
  assert_unstk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (unstk_done && unstk_err) |-> !sp_restore);
endmodule

// File: tb/bus_fault_capture_test.sv
module bus_fault_capture_test;
  localparam int AW = 8, NTAG = 4, PW = 2, TW = 2;

  logic clk = 0, rst_n = 0;
  logic fetch_err = 0, issue = 0, flush = 0, prec_err = 0, imp_err = 0;
  logic [TW-1:0] fetch_slot = 0, issue_slot = 0;
  logic [AW-1:0] prec_addr = 0, reg_wdata = 0;
  logic [PW-1:0] exec_prio = 0, fault_prio = 0;
  logic stk_err = 0, stk_done = 0, unstk_err = 0, unstk_done = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [AW-1:0] reg_rdata, fault_addr;
  logic [4:0] flags;
  logic addr_valid, imp_pending, sp_adjust, sp_restore;
  int errors = 0, checks = 0;
  bit done = 0;

  bus_fault_capture #(.AW(AW), .NTAG(NTAG), .PW(PW)) uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wclr(input logic [4:0] m);
    reg_wr = 1; reg_sel = 0; reg_wdata = {3'b0, m};
    tick;
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic set_all(input bit with_clr);
    fetch_err = 1; fetch_slot = 0;
    tick;
    fetch_err = 0;
    exec_prio = 3; fault_prio = 0;
    issue = 1; issue_slot = 0; stk_err = 1; unstk_err = 1; prec_err = 1; imp_err = 1;
    if (with_clr) begin reg_wr = 1; reg_sel = 0; reg_wdata = 8'h1F; end
    tick;
    issue = 0; stk_err = 0; unstk_err = 0; prec_err = 0; imp_err = 0;
    reg_wr = 0; reg_wdata = 0; exec_prio = 0;
    unstk_done = 1;
    tick;
    unstk_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 flags", flags, 0);
    chk("R1 valid", addr_valid, 0);
    chk("R1 pending", imp_pending, 0);
    chk("R1 rdata", reg_rdata, 0);
    rst_n = 1;
    tick;

    // R3 capture and R11 read mux
    prec_err = 1; prec_addr = 8'h5A;
    tick;
    prec_err = 0;
    chk("R3 flags", flags, 5'h02);
    chk("R3 addr", fault_addr, 8'h5A);
    chk("R3 valid", addr_valid, 1);
    reg_sel = 1; #1 chk("R11 sel1", reg_rdata, 8'h5A);
    reg_sel = 0; #1 chk("R11 sel0", reg_rdata, 8'h82);
    reg_wr = 1; reg_sel = 1; reg_wdata = 8'hFF;
    tick;
    reg_wr = 0; reg_sel = 0;
    chk("R11 wr sel1 addr", fault_addr, 8'h5A);
    chk("R11 wr sel1 flags", flags, 5'h02);

    // R4 hold, clear, recapture
    prec_err = 1; prec_addr = 8'h33;
    tick;
    prec_err = 0;
    chk("R4 hold", fault_addr, 8'h5A);
    wclr(5'h02);
    chk("R4 clear valid", addr_valid, 0);
    chk("R4 clear flag", flags, 0);
    prec_err = 1; prec_addr = 8'h71; reg_wr = 1; reg_wdata = 8'h02;
    tick;
    prec_err = 0; reg_wr = 0;
    chk("R4 recap addr", fault_addr, 8'h71);
    chk("R4 recap valid", addr_valid, 1);
    chk("R4 recap flag", flags, 5'h02);
    wclr(5'h1F);

    // R2 every clear mask over a full status field
    for (int m = 0; m < 32; m++) begin
      set_all(0);
      wclr(5'(m));
      chk("R2 mask", flags, 5'h1F & ~m);
      wclr(5'h1F);
    end
    set_all(1);
    chk("R2 set wins", flags, 5'h1F);
    wclr(5'h1F);
    chk("R2 all cleared", reg_rdata, 0);

    // R6 prefetch tags
    for (int s = 0; s < NTAG; s++) begin
      fetch_err = 1; fetch_slot = 2'(s);
      tick;
      fetch_err = 0;
      issue = 1; issue_slot = 2'(s + 1);
      tick;
      issue = 0;
      chk("R6 other slot", flags[0], 0);
      issue = 1; issue_slot = 2'(s);
      tick;
      issue = 0;
      chk("R6 tagged issue", flags[0], 1);
      wclr(5'h01);
      fetch_err = 1; fetch_slot = 2'(s);
      tick;
      fetch_err = 0; flush = 1;
      tick;
      flush = 0; issue = 1; issue_slot = 2'(s);
      tick;
      issue = 0;
      chk("R6 flushed", flags[0], 0);
    end

    // R7 every priority pair
    for (int e = 0; e < 4; e++)
      for (int f = 0; f < 4; f++) begin
        exec_prio = 2'(e); fault_prio = 2'(f); imp_err = 1;
        tick;
        imp_err = 0;
        chk("R7 pending", imp_pending, (e > f) ? 0 : 1);
        chk("R7 flag", flags[2], (e > f) ? 1 : 0);
        exec_prio = 3; fault_prio = 0;
        tick;
        chk("R7 delivered", flags[2], 1);
        chk("R7 drained", imp_pending, 0);
        wclr(5'h04);
      end

    // R8 precise while imprecise pending
    wclr(5'h1F);
    exec_prio = 0; fault_prio = 1; imp_err = 1;
    tick;
    imp_err = 0; prec_err = 1; prec_addr = 8'h44;
    tick;
    prec_err = 0;
    chk("R8 precise first", flags, 5'h02);
    chk("R8 still pending", imp_pending, 1);
    exec_prio = 2;
    tick;
    chk("R8 both set", flags, 5'h06);
    chk("R8 addr", fault_addr, 8'h44);
    wclr(5'h1F);

    // R5 non-precise errors leave the address alone
    fetch_err = 1; fetch_slot = 1;
    tick;
    fetch_err = 0; issue = 1; issue_slot = 1; imp_err = 1; exec_prio = 3; fault_prio = 0;
    stk_err = 1; unstk_err = 1;
    tick;
    issue = 0; imp_err = 0; stk_err = 0; unstk_err = 0;
    chk("R5 valid", addr_valid, 0);
    chk("R5 addr", fault_addr, 8'h44);
    chk("R5 flags", flags, 5'h1D);
    unstk_done = 1;
    tick;
    unstk_done = 0;
    wclr(5'h1F);

    // R9 stacking
    stk_err = 1;
    tick; tick;
    stk_done = 1;
    #1 chk("R9 adjust", sp_adjust, 1);
    tick;
    stk_err = 0; stk_done = 0;
    chk("R9 flag", flags, 5'h10);
    wclr(5'h1F);

    // R10 unstacking
    unstk_done = 1;
    #1 chk("R10 clean restore", sp_restore, 1);
    tick;
    unstk_done = 0; unstk_err = 1;
    tick;
    unstk_err = 0; unstk_done = 1;
    #1 chk("R10 suppressed", sp_restore, 0);
    tick;
    unstk_done = 0;
    chk("R10 flag", flags, 5'h08);
    unstk_err = 1; unstk_done = 1;
    #1 chk("R10 same cycle", sp_restore, 0);
    tick;
    unstk_err = 0;
    #1 chk("R10 next clean", sp_restore, 1);
    tick;
    unstk_done = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule